// File: doc/BRIEF.md
# Gate-Controlled Single-Bus Datapath

This block is the execution half of a small microcoded processor. Storage elements share one 32-bit internal bus: a program counter, a memory address register, a memory buffer register, an instruction register, a temporary register and a 32-entry register file. A 15-bit gate vector drives every transfer. The vector is the horizontal control word a sequencer issues each cycle, and each bit opens one path. A value moves when one gate puts a source on the bus and another gate lets a destination take it, both in the same cycle.

There are three bus sources: PC, MBR and T. The register file reaches the bus only through the adder and T. Memory is reached through a plain synchronous port. The address always shows MAR and the write data always shows MBR. A read strobe loads MBR from the returned word, and a write strobe asks memory to store MBR. The instruction register is exported so an outside sequencer can decode the opcode. The only arithmetic is the add used by the ADD instruction, which writes the sum of two registers to a third.

Top module: `gbus_datapath`

## Requirements
- R1: While reset is asserted and after it is released with all gates off, PC, MAR, MBR, IR, T and every register file entry are zero, so `ir`, `mem_addr` and `mem_wdata` read zero and `mem_rd`, `mem_wr` and `bus_conflict` are low.
- R2: Gate n is bit n-1 of `gates`, in this order: 1 PC to bus, 2 bus to MAR, 3 MBR to bus, 4 bus to MBR, 5 memory read, 6 bus to IR, 7 PC increment, 8 register read, 9 add, 10 adder to T, 11 T to bus, 12 register write, 13 memory write, 14 bus to PC. Bit 14 (gate 15) has no effect.
- R3: A bus-to-destination gate loads its destination at the clock edge only when exactly one source gate (1, 3 or 11) is on. With no source on, the destination keeps its value.
- R4: When two or more source gates are on, `bus_conflict` is high in that cycle and no bus destination (MAR, MBR, IR, PC, register file) takes the bus.
- R5: Gate 5 raises `mem_rd` in the same cycle and loads MBR from `mem_rdata` at the edge. It takes precedence over gate 4.
- R6: `mem_addr` always shows MAR and `mem_wdata` always shows MBR. Gate 13 raises `mem_wr` in the same cycle.
- R7: Gate 7 adds one to PC modulo 2^32. If gate 14 loads PC in the same cycle, the bus value wins.
- R8: Gate 8 drives the adder's two operands from register file entries selected by IR bits 21:17 and 16:12. With gate 8 off both operands are zero. With gate 9 off the adder output is zero. Gate 10 loads T with the adder output modulo 2^32.
- R9: Gate 12 writes the bus to the register file entry selected by IR bits 26:22. A read in the same cycle sees the old content.
- R10: `ir` carries the opcode in bits 31:27 (ADD = 00001). Fetch {1,2},{5},{3,6},{7} followed by {8,9,10},{11,12} leaves R[r1] = R[r2] + R[r3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gates | input | 15 | Control word, gate n at bit n-1 |
| mem_rdata | input | 32 | Word returned by memory at `mem_addr` |
| mem_addr | output | 32 | Memory address (MAR) |
| mem_wdata | output | 32 | Memory write data (MBR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir | output | 32 | Instruction register for decoding |
| bus_conflict | output | 1 | More than one bus source gate on |

## Verification
The bench goes after several corner cases:
- Bus contention. A design that let a contended bus through would corrupt MAR, IR or a register instead of holding them.
- A destination gate with no source. A design that loaded the idle bus would zero the destination.
- Memory read together with gate 4, and PC increment together with gate 14. Getting the priority wrong in either pair leaves the wrong value in MBR or PC.
- Additions that wrap around 2^32.
- A register write that hits the entry being read in the same cycle. A write-through read would put the new value into T.

A reference model steps alongside the design under thousands of random gate words. Any stray load therefore shows up at the memory port or on `ir`.

// File: rtl/dp_pkg.sv
package dp_pkg;

    // Gate positions inside the control word (gate n sits at bit n-1)
    localparam int G_PC_OUT   = 0;
    localparam int G_MAR_IN   = 1;
    localparam int G_MBR_OUT  = 2;
    localparam int G_MBR_IN   = 3;
    localparam int G_MEM_RD   = 4;
    localparam int G_IR_IN    = 5;
    localparam int G_PC_INC   = 6;
    localparam int G_REG_RD   = 7;
    localparam int G_ALU_ADD  = 8;
    localparam int G_ALU_TO_T = 9;
    localparam int G_T_OUT    = 10;
    localparam int G_REG_WR   = 11;
    localparam int G_MEM_WR   = 12;
    localparam int G_PC_IN    = 13;
    localparam int G_SPARE    = 14;
    localparam int GATE_COUNT = 15;

    localparam int OPCODE_W   = 5;

    typedef enum logic [2:0] {
        SRC_IDLE,
        SRC_PC,
        SRC_MBR,
        SRC_TMP,
        SRC_CLASH
    } bus_src_e;

endpackage

// File: rtl/dp_bus.sv
module dp_bus
    import dp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] pc_val,
    input  logic [W-1:0] mbr_val,
    input  logic [W-1:0] tmp_val,
    input  logic         pc_en,
    input  logic         mbr_en,
    input  logic         tmp_en,
    output logic [W-1:0] bus_val,
    output logic         bus_ok,
    output logic         bus_clash
);

    logic [1:0] drv_cnt;
    bus_src_e   src;

    always_comb begin
        drv_cnt = {1'b0, pc_en} + {1'b0, mbr_en} + {1'b0, tmp_en};
        if (drv_cnt > 2'd1)
            src = SRC_CLASH;
        else if (pc_en)
            src = SRC_PC;
        else if (mbr_en)
            src = SRC_MBR;
        else if (tmp_en)
            src = SRC_TMP;
        else
            src = SRC_IDLE;
    end

    always_comb begin
        unique case (src)
            SRC_PC:    bus_val = pc_val;
            SRC_MBR:   bus_val = mbr_val;
            SRC_TMP:   bus_val = tmp_val;
            SRC_IDLE:  bus_val = '0;
            SRC_CLASH: bus_val = '0;
            default:   bus_val = '0;
        endcase
    end

    assign bus_ok    = (src == SRC_PC) || (src == SRC_MBR) || (src == SRC_TMP);
    assign bus_clash = (src == SRC_CLASH);

endmodule

// File: rtl/dp_regbank.sv
module dp_regbank #(
    parameter int W  = 32,
    parameter int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_a_sel,
    input  logic [AW-1:0] rd_b_sel,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [W-1:0]  wr_val,
    output logic [W-1:0]  rd_a_val,
    output logic [W-1:0]  rd_b_val
);

    logic [W-1:0] cells [N];

    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[i] <= '0;
            else if (wr_en && (wr_sel == AW'(i)))
                cells[i] <= wr_val;
        end
    end

    always_comb begin
        rd_a_val = rd_en ? cells[rd_a_sel] : '0;
        rd_b_val = rd_en ? cells[rd_b_sel] : '0;
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         add_en,
    output logic [W-1:0] result
);

    always_comb begin
        result = add_en ? (opa + opb) : '0;
    end

endmodule

// File: rtl/gbus_datapath.sv
module gbus_datapath
    import dp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 32,
    parameter int GATE_W  = GATE_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GATE_W-1:0] gates,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] ir,
    output logic              bus_conflict
);

    localparam int RSEL_W = $clog2(REG_CNT);
    localparam int R1_LSB = DATA_W - OPCODE_W - RSEL_W;
    localparam int R2_LSB = R1_LSB - RSEL_W;
    localparam int R3_LSB = R2_LSB - RSEL_W;

    logic [DATA_W-1:0] pc_q, mar_q, mbr_q, ir_q, t_q;
    logic [DATA_W-1:0] bus_val, opa, opb, alu_out;
    logic              bus_ok;

    logic [RSEL_W-1:0] sel_r1, sel_r2, sel_r3;
    assign sel_r1 = ir_q[R1_LSB +: RSEL_W];
    assign sel_r2 = ir_q[R2_LSB +: RSEL_W];
    assign sel_r3 = ir_q[R3_LSB +: RSEL_W];

    dp_bus #(.W(DATA_W)) u_bus (
        .pc_val    (pc_q),
        .mbr_val   (mbr_q),
        .tmp_val   (t_q),
        .pc_en     (gates[G_PC_OUT]),
        .mbr_en    (gates[G_MBR_OUT]),
        .tmp_en    (gates[G_T_OUT]),
        .bus_val   (bus_val),
        .bus_ok    (bus_ok),
        .bus_clash (bus_conflict)
    );

    dp_regbank #(.W(DATA_W), .N(REG_CNT)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (gates[G_REG_RD]),
        .rd_a_sel (sel_r2),
        .rd_b_sel (sel_r3),
        .wr_en    (gates[G_REG_WR] && bus_ok),
        .wr_sel   (sel_r1),
        .wr_val   (bus_val),
        .rd_a_val (opa),
        .rd_b_val (opb)
    );

    dp_alu #(.W(DATA_W)) u_alu (
        .opa    (opa),
        .opb    (opb),
        .add_en (gates[G_ALU_ADD]),
        .result (alu_out)
    );

    // Program counter: bus load outranks increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else if (gates[G_PC_IN] && bus_ok)
            pc_q <= bus_val;
        else if (gates[G_PC_INC])
            pc_q <= pc_q + DATA_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mar_q <= '0;
        else if (gates[G_MAR_IN] && bus_ok)
            mar_q <= bus_val;
    end

    // Memory buffer: memory read outranks bus load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mbr_q <= '0;
        else if (gates[G_MEM_RD])
            mbr_q <= mem_rdata;
        else if (gates[G_MBR_IN] && bus_ok)
            mbr_q <= bus_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ir_q <= '0;
        else if (gates[G_IR_IN] && bus_ok)
            ir_q <= bus_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            t_q <= '0;
        else if (gates[G_ALU_TO_T])
            t_q <= alu_out;
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign mem_rd    = gates[G_MEM_RD];
    assign mem_wr    = gates[G_MEM_WR];
    assign ir        = ir_q;

endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
    parameter int W  = 32,
    parameter int GW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic [GW-1:0] gates,
    input logic [W-1:0]  mem_rdata,
    input logic [W-1:0]  mem_addr,
    input logic [W-1:0]  mem_wdata,
    input logic [W-1:0]  ir,
    input logic          bus_conflict,
    input logic [W-1:0]  pc_q,
    input logic [W-1:0]  t_q
);

    logic no_src;
    assign no_src = !(gates[0] || gates[2] || gates[10]);

    a_r4_clash_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        bus_conflict |=> ($stable(ir) && $stable(mem_addr)));

    a_r5_read_loads_mbr: assert property (@(posedge clk) disable iff (!rst_n)
        gates[4] |=> (mem_wdata == $past(mem_rdata)));

    a_r7_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (gates[6] && !gates[13]) |=> (pc_q == $past(pc_q) + W'(1)));

    a_r3_idle_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (gates[1] && no_src) |=> $stable(mem_addr));

    a_r8_add_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (gates[9] && !gates[8]) |=> (t_q == '0));

    a_r2_spare_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (gates == GW'(1 << 14)) |=> ($stable(ir) && $stable(mem_addr) && $stable(mem_wdata)));

endmodule

bind gbus_datapath dp_checker #(.W(DATA_W), .GW(GATE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gates        (gates),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .ir           (ir),
    .bus_conflict (bus_conflict),
    .pc_q         (pc_q),
    .t_q          (t_q)
);

// File: tb/sim_gbus_datapath.sv
`timescale 1ns/1ps
module sim_gbus_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] gates = '0;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr, mem_wdata, ir;
    logic        mem_rd, mem_wr, bus_conflict;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    logic [31:0] mem [64];
    assign mem_rdata = mem[mem_addr[5:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;

    gbus_datapath u0 (
        .clk(clk), .rst_n(rst_n), .gates(gates), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .ir(ir), .bus_conflict(bus_conflict)
    );

    // reference state
    logic [31:0] m_pc, m_mar, m_mbr, m_ir, m_t;
    logic [31:0] m_rf [32];

    function automatic logic [14:0] gn(int n);
        return 15'(1) << (n - 1);
    endfunction

    function automatic logic [31:0] mk(logic [4:0] op, logic [4:0] a, logic [4:0] b, logic [4:0] c);
        return {op, a, b, c, 12'h0};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // one cycle: drive at negedge, check strobes, step model, check state
    task automatic step(logic [14:0] g, string tag);
        int          cnt;
        logic        ok;
        logic [31:0] bv, ra, rb, sum;
        logic [31:0] n_pc, n_mar, n_mbr, n_ir, n_t;
        gates = g;
        #1;
        cnt = int'(g[0]) + int'(g[2]) + int'(g[10]);
        ok  = (cnt == 1);
        bv  = !ok ? 32'h0 : g[0] ? m_pc : g[2] ? m_mbr : m_t;
        chk(tag, "mem_rd", {31'h0, mem_rd}, {31'h0, g[4]});
        chk(tag, "mem_wr", {31'h0, mem_wr}, {31'h0, g[12]});
        chk(tag, "bus_conflict", {31'h0, bus_conflict}, {31'h0, cnt > 1});
        ra  = g[7] ? m_rf[m_ir[21:17]] : 32'h0;
        rb  = g[7] ? m_rf[m_ir[16:12]] : 32'h0;
        sum = g[8] ? ra + rb : 32'h0;
        n_pc  = (g[13] && ok) ? bv : g[6] ? m_pc + 32'd1 : m_pc;
        n_mar = (g[1] && ok) ? bv : m_mar;
        n_mbr = g[4] ? mem[m_mar[5:0]] : (g[3] && ok) ? bv : m_mbr;
        n_ir  = (g[5] && ok) ? bv : m_ir;
        n_t   = g[9] ? sum : m_t;
        if (g[11] && ok) m_rf[m_ir[26:22]] = bv;
        @(posedge clk);
        m_pc = n_pc; m_mar = n_mar; m_mbr = n_mbr; m_ir = n_ir; m_t = n_t;
        @(negedge clk);
        chk(tag, "ir", ir, m_ir);
        chk(tag, "mem_addr", mem_addr, m_mar);
        chk(tag, "mem_wdata", mem_wdata, m_mbr);
    endtask

    task automatic load_ir(logic [31:0] w, string tag);
        mem[m_mar[5:0]] = w;
        step(gn(5), tag);
        step(gn(3) | gn(6), tag);
    endtask

    task automatic load_reg(logic [4:0] idx, logic [31:0] v, string tag);
        load_ir(mk(5'd0, idx, 5'd0, 5'd0), tag);
        mem[m_mar[5:0]] = v;
        step(gn(5), tag);
        step(gn(3) | gn(12), tag);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) mem[i] = $urandom;
        m_pc = 0; m_mar = 0; m_mbr = 0; m_ir = 0; m_t = 0;
        for (int i = 0; i < 32; i++) m_rf[i] = 0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "ir", ir, 32'h0);
        chk("R1", "mem_addr", mem_addr, 32'h0);
        chk("R1", "mem_wdata", mem_wdata, 32'h0);
        chk("R1", "strobes", {29'h0, mem_rd, mem_wr, bus_conflict}, 32'h0);
        @(negedge clk);
        step(15'h0, "R1");

        // R2: spare gate alone does nothing
        step(gn(15), "R2");

        // R9 / R8: load operands with wrapping sum
        load_reg(5'd3, 32'hFFFF_FFF0, "R9");
        load_reg(5'd4, 32'h0000_0025, "R9");

        // R10: fetch and execute ADD r5 = r3 + r4
        mem[0] = mk(5'b00001, 5'd5, 5'd3, 5'd4);
        step(gn(1) | gn(2), "R10");
        step(gn(5), "R10");
        step(gn(3) | gn(6), "R10");
        chk("R10", "opcode", {27'h0, ir[31:27]}, 32'h1);
        step(gn(7), "R10");
        step(gn(8) | gn(9) | gn(10), "R10");
        step(gn(11) | gn(12), "R10");
        load_ir(mk(5'd0, 5'd0, 5'd5, 5'd0), "R10");
        step(gn(8) | gn(9) | gn(10), "R10");
        step(gn(11) | gn(4), "R10");
        chk("R10", "r5 sum", mem_wdata, 32'h0000_0015);

        // R8: adder gated by register read
        step(gn(9) | gn(10), "R8");
        step(gn(11) | gn(2), "R8");
        chk("R8", "T without read", mem_addr, 32'h0);

        // R3: destination gate with no source keeps value
        step(gn(4), "R3");
        chk("R3", "mbr hold", mem_wdata, 32'h0000_0015);

        // R4: two sources at once
        step(gn(1) | gn(3) | gn(2) | gn(6), "R4");
        step(gn(1) | gn(11) | gn(14), "R4");

        // R5: memory read beats bus load
        mem[m_mar[5:0]] = 32'hA5A5_0001;
        step(gn(5) | gn(1) | gn(4), "R5");
        chk("R5", "mbr from memory", mem_wdata, 32'hA5A5_0001);

        // R6: memory write presents MBR at MAR
        step(gn(13), "R6");
        chk("R6", "memory word", mem[m_mar[5:0]], 32'hA5A5_0001);

        // R7: PC wrap and bus-over-increment priority
        mem[m_mar[5:0]] = 32'hFFFF_FFFF;
        step(gn(5), "R7");
        step(gn(3) | gn(14) | gn(7), "R7");
        step(gn(7), "R7");
        step(gn(1) | gn(2), "R7");
        chk("R7", "pc wrapped", mem_addr, 32'h0);

        // R9: write and read of same entry in one cycle
        load_ir(mk(5'd0, 5'd6, 5'd6, 5'd6), "R9");
        step(gn(3) | gn(12) | gn(8) | gn(9) | gn(10), "R9");

        // random mix, all state cross-checked
        for (int k = 0; k < 3000; k++) begin
            logic [14:0] g;
            for (int b = 0; b < 15; b++) g[b] = ($urandom_range(3) == 0);
            step(g, "R3");
        end

        summary();
    end

endmodule